// File: doc/BRIEF.md
# Cipher Key and IV Register Bank

This block holds the secret key and the initialization vector of a block-cipher engine. Software writes eight 32-bit key words, arranged as four left/right pairs, and four 32-bit IV words through a simple word-addressed write port. A separate combinational read port returns the IV words and a status word. The key words never read back. While the engine reports busy, writes to key or IV words are dropped, and a sticky flag records that this happened.

The engine does not see the raw store. From a three-bit mode input, the block presents a right-aligned key window and an IV suited to the selected algorithm. Unused upper bits of both outputs are forced to zero. Key bit 0 of the algorithm is always the most significant bit of the used window.

Top module: `cipher_keyiv_bank`

## Requirements
- R1: After reset, every key word, IV word and the write-ignored flag are zero, so `key_out`, `iv_out` and every read return zero.
- R2: When `busy` is low, a write to address 2p (left) or 2p+1 (right), for p = 0..3, stores the key word of pair p. The 256-bit store is {P0L, P0R, P1L, P1R, P2L, P2R, P3L, P3R}, with P0L in the most significant bits. The new value shows on `key_out` right after the write edge.
- R3: A write to a key address (0..7) while `busy` is high leaves the key store, and therefore `key_out`, unchanged.
- R4: When `busy` is low, writes to addresses 8..11 store IV words IV0L, IV0R, IV1L and IV1R, and reads of those addresses return the stored words. A write to an IV address while `busy` is high leaves the stored word unchanged.
- R5: Reads of key addresses 0..7 always return zero.
- R6: In AES modes, `key_out` carries part of the store and zeroes the bits above it:
  - mode 2 (AES-128) carries store bits [127:0];
  - mode 3 (AES-192) carries bits [191:0];
  - mode 4 (AES-256) carries all 256 bits.
- R7: In DES and TDES modes, `key_out` carries the pair-1 to pair-3 keys and zeroes the bits above them:
  - mode 0 (DES) gives {192'b0, P1L, P1R}, which is K1 only;
  - mode 1 (TDES) gives {64'b0, K1, K2, K3}, where K1 is pair 1, K2 is pair 2 and K3 is pair 3. Pair 0 is unused in both modes.
- R8: `iv_out` depends on the mode:
  - in AES modes it is {IV0L, IV0R, IV1L, IV1R};
  - in DES and TDES modes it is {64'b0, IV0L, IV0R}.
- R9: A key or IV write while `busy` is high sets `wr_ignored` at that edge, and the flag stays set. Address 12 is the status word, with the flag in bit 0:
  - a write of 1 to bit 0 clears the flag, even while `busy` is high;
  - a write of 0 has no effect.
- R10: Mode codes 5..7 give zero on `key_out` and `iv_out`. Addresses 13..15 read as zero, and writes to them change nothing and do not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 32 | Read data (combinational) |
| busy | input | 1 | Engine busy status |
| mode | input | 3 | Algorithm select: 0 DES, 1 TDES, 2 AES-128, 3 AES-192, 4 AES-256 |
| key_out | output | 256 | Aligned key for the engine |
| iv_out | output | 128 | Aligned IV for the engine |
| wr_ignored | output | 1 | Sticky flag: a write was dropped because `busy` was high |

## Verification
- **Registered results.** Key words, IV words and the flag are registers, so their effect on `key_out`, `iv_out`, `rd_data` and `wr_ignored` is due at the write clock edge itself. Nothing adds further delay.
- **Combinational results.** A change of `mode` or `rd_addr` shows in the same cycle.
- **Sampling.** The driver changes inputs just after a rising edge and queues the expected value. The monitor pops and compares at the following falling edge, so every comparison falls half a cycle after the edge on which its result is due.

// File: rtl/cipher_keyiv_bank.sv
module cipher_keyiv_bank #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [WORD_W-1:0]   rd_data,
  input  logic                busy,
  input  logic [2:0]          mode,
  output logic [8*WORD_W-1:0] key_out,
  output logic [4*WORD_W-1:0] iv_out,
  output logic                wr_ignored
);
  localparam int KEY_WORDS = 8;
  localparam int IV_WORDS  = 4;
  localparam int PAIR_W    = 2 * WORD_W;
  localparam int KEY_W     = KEY_WORDS * WORD_W;
  localparam int IV_W      = IV_WORDS * WORD_W;
  localparam int STAT_ADDR = KEY_WORDS + IV_WORDS;

  localparam logic [2:0] M_DES    = 3'd0;
  localparam logic [2:0] M_TDES   = 3'd1;
  localparam logic [2:0] M_AES128 = 3'd2;
  localparam logic [2:0] M_AES192 = 3'd3;
  localparam logic [2:0] M_AES256 = 3'd4;

  logic [WORD_W-1:0] key_q [KEY_WORDS];
  logic [WORD_W-1:0] iv_q  [IV_WORDS];
  logic [KEY_W-1:0]  key_store;
  logic [IV_W-1:0]   iv_store;
  logic              flag_q;

  wire wr_key  = wr_en && (int'(wr_addr) < KEY_WORDS);
  wire wr_iv   = wr_en && (int'(wr_addr) >= KEY_WORDS) && (int'(wr_addr) < STAT_ADDR);
  wire wr_stat = wr_en && (int'(wr_addr) == STAT_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < KEY_WORDS; k++) key_q[k] <= '0;
      for (int i = 0; i < IV_WORDS; i++)  iv_q[i]  <= '0;
    end else if (!busy) begin
      for (int k = 0; k < KEY_WORDS; k++)
        if (wr_key && int'(wr_addr) == k) key_q[k] <= wr_data;
      for (int i = 0; i < IV_WORDS; i++)
        if (wr_iv && int'(wr_addr) == KEY_WORDS + i) iv_q[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         flag_q <= 1'b0;
    else if (busy && (wr_key || wr_iv)) flag_q <= 1'b1;
    else if (wr_stat && wr_data[0])     flag_q <= 1'b0;
  end

  assign wr_ignored = flag_q;

  always_comb begin
    for (int k = 0; k < KEY_WORDS; k++)
      key_store[KEY_W-1-WORD_W*k -: WORD_W] = key_q[k];
    for (int i = 0; i < IV_WORDS; i++)
      iv_store[IV_W-1-WORD_W*i -: WORD_W] = iv_q[i];
  end

  always_comb begin
    case (mode)
      M_DES:    key_out = KEY_W'(key_store[3*PAIR_W-1:2*PAIR_W]);
      M_TDES:   key_out = KEY_W'(key_store[3*PAIR_W-1:0]);
      M_AES128: key_out = KEY_W'(key_store[4*WORD_W-1:0]);
      M_AES192: key_out = KEY_W'(key_store[6*WORD_W-1:0]);
      M_AES256: key_out = key_store;
      default:  key_out = '0;
    endcase
  end

  always_comb begin
    case (mode)
      M_DES, M_TDES:               iv_out = IV_W'(iv_store[IV_W-1 -: PAIR_W]);
      M_AES128, M_AES192, M_AES256: iv_out = iv_store;
      default:                      iv_out = '0;
    endcase
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < IV_WORDS; i++)
      if (int'(rd_addr) == KEY_WORDS + i) rd_data = iv_q[i];
    if (int'(rd_addr) == STAT_ADDR) rd_data = WORD_W'(flag_q);
  end
endmodule

module keyiv_bank_chk #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic [WORD_W-1:0]   wr_data,
  input logic [ADDR_W-1:0]   rd_addr,
  input logic [WORD_W-1:0]   rd_data,
  input logic                busy,
  input logic [2:0]          mode,
  input logic [8*WORD_W-1:0] key_out,
  input logic [4*WORD_W-1:0] iv_out,
  input logic                wr_ignored,
  input logic [8*WORD_W-1:0] key_store,
  input logic [4*WORD_W-1:0] iv_store
);
  a_r3_key_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && int'(wr_addr) < 8) |=> $stable(key_store));

  a_r4_iv_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && int'(wr_addr) >= 8 && int'(wr_addr) < 12) |=> $stable(iv_store));

  a_r9_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && int'(wr_addr) < 12) |=> wr_ignored);

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ignored && !(wr_en && int'(wr_addr) == 12 && wr_data[0])) |=> wr_ignored);

  a_r5_key_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_addr) < 8) |-> (rd_data == '0));

  a_r6_aes128_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2) |-> (key_out[8*WORD_W-1:4*WORD_W] == '0));

  a_r10_reserved_mode_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mode > 3'd4) |-> (key_out == '0 && iv_out == '0));
endmodule

bind cipher_keyiv_bank keyiv_bank_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/cipher_keyiv_bank_test.sv
`timescale 1ns/1ps
module cipher_keyiv_bank_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [3:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic [3:0]   rd_addr = '0;
  logic [31:0]  rd_data;
  logic         busy = 1'b0;
  logic [2:0]   mode = 3'd4;
  logic [255:0] key_out;
  logic [127:0] iv_out;
  logic         wr_ignored;

  cipher_keyiv_bank uut (.*);

  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  int           q_sel [$];
  logic [255:0] q_val [$];
  string        q_req [$];

  logic [31:0] kw [8];
  logic [31:0] ivw [4];

  function automatic logic [255:0] exp_key(input logic [2:0] m);
    logic [255:0] s;
    s = {kw[0], kw[1], kw[2], kw[3], kw[4], kw[5], kw[6], kw[7]};
    case (m)
      3'd0: exp_key = {192'd0, kw[2], kw[3]};
      3'd1: exp_key = {64'd0, kw[2], kw[3], kw[4], kw[5], kw[6], kw[7]};
      3'd2: exp_key = {128'd0, s[127:0]};
      3'd3: exp_key = {64'd0, s[191:0]};
      3'd4: exp_key = s;
      default: exp_key = '0;
    endcase
  endfunction

  function automatic logic [127:0] exp_iv(input logic [2:0] m);
    if (m <= 3'd1)      exp_iv = {64'd0, ivw[0], ivw[1]};
    else if (m <= 3'd4) exp_iv = {ivw[0], ivw[1], ivw[2], ivw[3]};
    else                exp_iv = '0;
  endfunction

  always @(negedge clk) begin
    if (q_sel.size() > 0) begin
      int s;
      logic [255:0] e, a;
      string r;
      s = q_sel.pop_front();
      e = q_val.pop_front();
      r = q_req.pop_front();
      case (s)
        0: a = {224'd0, rd_data};
        1: a = key_out;
        2: a = {128'd0, iv_out};
        default: a = {255'd0, wr_ignored};
      endcase
      tests++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", r, s, a, e);
      end
    end
  end

  task automatic expect_item(input int sel, input logic [255:0] v, input string req);
    q_sel.push_back(sel);
    q_val.push_back(v);
    q_req.push_back(req);
    @(negedge clk);
    #1;
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    if (!busy && a < 4'd8) kw[a] = d;
    if (!busy && a >= 4'd8 && a < 4'd12) ivw[a-4'd8] = d;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] e, input string req);
    rd_addr = a;
    expect_item(0, {224'd0, e}, req);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) kw[i] = '0;
    for (int i = 0; i < 4; i++) ivw[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    expect_item(1, 256'd0, "R1");
    expect_item(2, 256'd0, "R1");
    expect_item(3, 256'd1 - 256'd1, "R1");
    rd_chk(4'd9, 32'd0, "R1");

    // R2: key writes, layout visible in AES-256
    for (int k = 0; k < 8; k++) do_wr(4'(k), 32'h1111_0000 * (k + 1) + 32'h00A5 + k);
    mode = 3'd4; expect_item(1, exp_key(3'd4), "R2");
    // R6: AES windows
    mode = 3'd2; expect_item(1, exp_key(3'd2), "R6");
    mode = 3'd3; expect_item(1, exp_key(3'd3), "R6");
    mode = 3'd4; expect_item(1, exp_key(3'd4), "R6");
    // R7: DES and TDES
    mode = 3'd0; expect_item(1, exp_key(3'd0), "R7");
    mode = 3'd1; expect_item(1, exp_key(3'd1), "R7");
    // R5: key words never read back
    for (int k = 0; k < 8; k++) rd_chk(4'(k), 32'd0, "R5");

    // R4: IV write and read back
    do_wr(4'd8,  32'hDEAD_0001);
    do_wr(4'd9,  32'hBEEF_0002);
    do_wr(4'd10, 32'hCAFE_0003);
    do_wr(4'd11, 32'hF00D_0004);
    for (int i = 0; i < 4; i++) rd_chk(4'(8 + i), ivw[i], "R4");
    // R8: IV alignment
    mode = 3'd4; expect_item(2, {128'd0, exp_iv(3'd4)}, "R8");
    mode = 3'd2; expect_item(2, {128'd0, exp_iv(3'd2)}, "R8");
    mode = 3'd1; expect_item(2, {128'd0, exp_iv(3'd1)}, "R8");
    mode = 3'd0; expect_item(2, {128'd0, exp_iv(3'd0)}, "R8");

    // R3 and R4: writes dropped while busy, R9 flag
    busy = 1'b1;
    mode = 3'd4;
    do_wr(4'd3, 32'h0BAD_0BAD);
    expect_item(1, exp_key(3'd4), "R3");
    expect_item(3, 256'd1, "R9");
    do_wr(4'd10, 32'h0BAD_1111);
    rd_chk(4'd10, 32'hCAFE_0003, "R4");
    // R9: write of 0 does nothing, write of 1 clears even while busy
    do_wr(4'd12, 32'd0);
    expect_item(3, 256'd1, "R9");
    rd_chk(4'd12, 32'd1, "R9");
    do_wr(4'd12, 32'd1);
    expect_item(3, 256'd0, "R9");
    busy = 1'b0;

    // R2: write accepted again once idle
    do_wr(4'd3, 32'h7777_3333);
    expect_item(1, exp_key(3'd4), "R2");
    expect_item(3, 256'd0, "R9");

    // R10: reserved modes and addresses
    mode = 3'd5; expect_item(1, 256'd0, "R10");
    expect_item(2, 256'd0, "R10");
    mode = 3'd7; expect_item(1, 256'd0, "R10");
    do_wr(4'd14, 32'hFFFF_FFFF);
    rd_chk(4'd14, 32'd0, "R10");
    expect_item(3, 256'd0, "R10");
    mode = 3'd4; expect_item(1, exp_key(3'd4), "R10");
    busy = 1'b1;
    do_wr(4'd13, 32'h1234_5678);
    expect_item(3, 256'd0, "R10");
    busy = 1'b0;

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule